// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a station-management master for an Ethernet PHY. A requester presents a read or write command made of a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The engine then runs one complete management frame: a long run of idle ones, a 16-bit command header and 16 data bits. It generates the management clock from the system clock, drives the data line, and on reads releases the line and samples the PHY's reply.

The management clock half-period is `CLK_DIV` system clocks, and `CLK_DIV` must be at least 3. Every data-line update happens one system clock after a falling management-clock edge. Read results are returned unchanged together with a one-cycle done strobe. Patterns such as all ones or all zeros, which may mean that no PHY is present, are left for the requester to interpret.

Top module: `mdio_frame_engine`

## Requirements
- R1: Every frame starts with 32 management-clock periods during which the data line is driven (output enable 1) at value 1.
- R2: The 16 header bits are sent most significant bit first. The header is 16'h6000 for a read or 16'h5002 for a write, ORed with the PHY address shifted left by 7 and the register address shifted left by 2.
- R3: On a read, the output enable is 0 for the last two header bits (header bits 1 and 0) and for all 16 data bits.
- R4: The data-line value and output enable change only while the management clock is low. They never change on the same system clock edge as a management clock edge, and each update follows a falling edge by one system clock.
- R5: On a read, one data bit is sampled at the end of each low phase of the 16 data periods, most significant bit first. The 16-bit result appears on `rdData` no later than the cycle in which `xferDone` pulses. `xferDone` pulses for one cycle, in the cycle in which `reqReady` returns high.
- R6: On a write, the two turnaround bits are driven as 1 then 0, and the 16 write-data bits follow, most significant bit first, with the output enable at 1.
- R7: The management clock is high for exactly `CLK_DIV` system clocks per period. A frame has exactly 64 rising edges, and the clock is low when the engine returns to ready.
- R8: A request is taken only in a cycle where `reqValid` and `reqReady` are both high. `reqReady` stays low from the cycle after acceptance through the final low phase. Requests raised while `reqReady` is low are ignored and start no frame.
- R9: Read values of 16'hFFFF and 16'h0000 are returned unchanged.
- R10: After reset, `reqReady` is 1, the management clock is 0, the output enable is 0 and `xferDone` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle and able to take a request |
| reqWrite | input | 1 | 1 for a write frame, 0 for a read frame |
| reqPhy | input | 5 | PHY address |
| reqReg | input | 5 | Register address |
| reqData | input | 16 | Write value |
| rdData | output | 16 | Value returned by the last read |
| xferDone | output | 1 | One-cycle end-of-frame strobe |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data-line value when driving |
| mdioOe | output | 1 | Data-line output enable |
| mdioIn | input | 1 | Data-line value seen at the pin |

## Verification
The assertions check, on every cycle, the clock-relative timing of the data line, the high-phase length of the management clock, the quiet idle state, the drop of ready after acceptance, and the alignment of the done strobe with ready. Frame content needs a model of the PHY, so only the bench scenarios can show it. That content is the preamble, the header bit placement for both patterns, where the line is released on reads, the write data order and the values returned by reads, including all-ones and all-zeros. The bench scenarios also show that a request raised mid-frame is dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 16;
  localparam int DATA_BITS  = 16;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + DATA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  // first period in which a read frees the line (turnaround)
  localparam int RELEASE_IDX = PRE_BITS + HDR_BITS - 2;
  // first data period
  localparam int DATA_IDX    = PRE_BITS + HDR_BITS;
  localparam logic [HDR_BITS-1:0] RD_CMD = 16'h6000;
  localparam logic [HDR_BITS-1:0] WR_CMD = 16'h5002;

  typedef struct packed {
    logic load;     // latch a new frame
    logic txStep;   // present next bit on the line
    logic txDrive;  // output enable for that bit
    logic rxStep;   // shift in one read bit
    logic park;     // release line after last period
    logic capture;  // publish read result
  } dpCtl_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output logic   mdc,
  output logic   xferDone,
  output dpCtl_t ctl
);
  localparam int PH_W = $clog2(2 * CLK_DIV);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * CLK_DIV - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} state_t;

  state_t state;
  logic [PH_W-1:0] phCnt;
  logic [IDX_W-1:0] bitIdx;
  logic isRead;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.txStep  = (state == ST_RUN) && (phCnt == '0);
    ctl.txDrive = !(isRead && (bitIdx >= IDX_W'(RELEASE_IDX)));
    ctl.rxStep  = (state == ST_RUN) && (phCnt == PH_RISE) && isRead
                  && (bitIdx >= IDX_W'(DATA_IDX));
    ctl.park    = (state == ST_TAIL) && (phCnt == '0);
    ctl.capture = ctl.park && isRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phCnt    <= '0;
      bitIdx   <= '0;
      isRead   <= 1'b0;
      mdc      <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_RUN;
            phCnt  <= '0;
            bitIdx <= '0;
            isRead <= !reqWrite;
          end
        end
        ST_RUN: begin
          if (phCnt == PH_RISE) mdc <= 1'b1;
          if (phCnt == PH_LAST) begin
            mdc   <= 1'b0;
            phCnt <= '0;
            if (bitIdx == LAST_IDX) state <= ST_TAIL;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (phCnt == PH_RISE) begin
            state    <= ST_IDLE;
            xferDone <= 1'b1;
            phCnt    <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic                 reqWrite,
  input  logic [4:0]           reqPhy,
  input  logic [4:0]           reqReg,
  input  logic [DATA_BITS-1:0] reqData,
  input  logic                 mdioIn,
  output logic                 mdioOut,
  output logic                 mdioOe,
  output logic [DATA_BITS-1:0] rdData
);
  logic [FRAME_BITS-1:0] txSr;
  logic [DATA_BITS-1:0]  rxSr;
  logic [HDR_BITS-1:0]   header;

  always_comb begin
    header = (reqWrite ? WR_CMD : RD_CMD) | {4'b0000, reqPhy, reqReg, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSr    <= '1;
      rxSr    <= '0;
      rdData  <= '0;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else begin
      if (ctl.load)
        txSr <= {{PRE_BITS{1'b1}}, header, reqWrite ? reqData : {DATA_BITS{1'b1}}};
      else if (ctl.txStep)
        txSr <= {txSr[FRAME_BITS-2:0], 1'b1};
      if (ctl.txStep) begin
        mdioOut <= txSr[FRAME_BITS-1];
        mdioOe  <= ctl.txDrive;
      end
      if (ctl.rxStep) rxSr <= {rxSr[DATA_BITS-2:0], mdioIn};
      if (ctl.park) begin
        mdioOut <= 1'b1;
        mdioOe  <= 1'b0;
      end
      if (ctl.capture) rdData <= rxSr;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [4:0]  reqPhy,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqData,
  output logic [15:0] rdData,
  output logic        xferDone,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpCtl_t ctl;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .mdc(mdc), .xferDone(xferDone), .ctl(ctl)
  );

  mdio_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqData(reqData), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic xferDone
);
  localparam int CNT_W = $clog2(CLK_DIV + 1) + 1;
  logic [CNT_W-1:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN) hiCnt <= '0;
    else if (mdc) hiCnt <= hiCnt + 1'b1;
    else hiCnt <= '0;
  end

  // R7
  mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdc) |-> hiCnt == CNT_W'(CLK_DIV));

  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOut != $past(mdioOut) || mdioOe != $past(mdioOe)) |-> (!mdc && !$past(mdc)));

  // R4
  rise_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdioOut) && $stable(mdioOe)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!mdc && !mdioOe));

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R5
  done_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (reqReady && $rose(reqReady)));
endmodule

bind mdio_frame_engine mdio_frame_engine_chk #(.CLK_DIV(CLK_DIV)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .xferDone(xferDone)
);

// File: tb/mdio_frame_engine_test.sv
module mdio_frame_engine_test;
  localparam int DIV = 4;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 5'd1,  5'd1,  16'h796D},
    '{1'b1, 5'd31, 5'd31, 16'hA5C3},
    '{1'b0, 5'd0,  5'd0,  16'hFFFF},
    '{1'b0, 5'd17, 5'd2,  16'h0000},
    '{1'b1, 5'd0,  5'd0,  16'h0000},
    '{1'b1, 5'd10, 5'd21, 16'h8001},
    '{1'b0, 5'd21, 5'd10, 16'h8001}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0] reqPhy = '0, reqReg = '0;
  logic [15:0] reqData = '0;
  logic reqReady, xferDone, mdc, mdioOut, mdioOe, mdioIn;
  logic [15:0] rdData;

  int tests = 0, fails = 0;
  int riseTotal = 0, base = 0, viol = 0, hiLen = 0, lastHi = 0;
  logic [15:0] phyWord = '0;
  logic bitOut [64];
  logic bitOe [64];
  logic prevMdc = 1'b0, prevOut = 1'b1, prevOe = 1'b0;

  always #5 clk = ~clk;

  mdio_frame_engine #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqPhy(reqPhy), .reqReg(reqReg), .reqData(reqData),
    .rdData(rdData), .xferDone(xferDone), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: drives reply bit after each rise from rise 48 on
  assign mdioIn = mdioOe ? mdioOut :
    ((riseTotal - base >= 48 && riseTotal - base < 64) ? phyWord[63 - (riseTotal - base)] : 1'b1);

  always @(posedge mdc) begin
    if (riseTotal - base < 64 && riseTotal - base >= 0) begin
      bitOut[riseTotal - base] = mdioOut;
      bitOe[riseTotal - base]  = mdioOe;
    end
    riseTotal = riseTotal + 1;
  end

  // timing monitor for R4 and R7
  always @(negedge clk) begin
    if (rstN) begin
      if ((mdioOut != prevOut || mdioOe != prevOe) && (mdc != prevMdc || mdc)) viol = viol + 1;
      if (mdc) hiLen = hiLen + 1;
      else if (prevMdc) begin lastHi = hiLen; hiLen = 0; end
    end
    prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startReq(input vec_t v);
    @(negedge clk);
    base = riseTotal;
    phyWord = v.data;
    reqValid = 1'b1; reqWrite = v.wr; reqPhy = v.phy; reqReg = v.rg; reqData = v.data;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 ready low after accept", {31'd0, reqReady}, 32'd0);
  endtask

  task automatic waitDone();
    while (!xferDone) @(negedge clk);
  endtask

  task automatic checkFrame(input vec_t v);
    logic [31:0] pre, preOe;
    logic [15:0] hdr, hdrOe, dat, datOe, expHdr;
    for (int i = 0; i < 32; i++) begin pre[31-i] = bitOut[i]; preOe[31-i] = bitOe[i]; end
    for (int i = 0; i < 16; i++) begin
      hdr[15-i] = bitOut[32+i]; hdrOe[15-i] = bitOe[32+i];
      dat[15-i] = bitOut[48+i]; datOe[15-i] = bitOe[48+i];
    end
    expHdr = (v.wr ? 16'h5002 : 16'h6000) | (16'(v.phy) << 7) | (16'(v.rg) << 2);
    chk("R1 preamble ones", pre, 32'hFFFF_FFFF);
    chk("R1 preamble driven", preOe, 32'hFFFF_FFFF);
    chk("R2 header bits", {16'd0, hdr[15:2]}, {16'd0, expHdr[15:2]});
    chk("R2 header driven", {30'd0, hdrOe[15:14]}, 32'd3);
    chk("R7 rise count", riseTotal - base, 64);
    chk("R7 mdc low at ready", {31'd0, mdc}, 32'd0);
    if (v.wr) begin
      chk("R6 turnaround value", {30'd0, hdr[1:0]}, 32'd2);
      chk("R6 turnaround driven", {30'd0, hdrOe[1:0]}, 32'd3);
      chk("R6 write data", {16'd0, dat}, {16'd0, v.data});
      chk("R6 write data driven", {16'd0, datOe}, 32'h0000_FFFF);
    end else begin
      chk("R3 turnaround released", {16'd0, hdrOe}, 32'h0000_FFFC);
      chk("R3 data released", {16'd0, datOe}, 32'd0);
      if (v.data == 16'hFFFF || v.data == 16'h0000)
        chk("R9 extreme read value", {16'd0, rdData}, {16'd0, v.data});
      else
        chk("R5 read data", {16'd0, rdData}, {16'd0, v.data});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", {31'd0, reqReady}, 32'd1);
    chk("R10 mdc", {31'd0, mdc}, 32'd0);
    chk("R10 oe", {31'd0, mdioOe}, 32'd0);
    chk("R10 done", {31'd0, xferDone}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < 7; n++) begin
      startReq(VECS[n]);
      waitDone();
      checkFrame(VECS[n]);
    end

    // R8: request raised mid-frame is ignored
    startReq('{1'b0, 5'd3, 5'd4, 16'h1234});
    repeat (100) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqPhy = 5'd9; reqReg = 5'd9; reqData = 16'hDEAD;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    checkFrame('{1'b0, 5'd3, 5'd4, 16'h1234});
    repeat (40) @(negedge clk);
    chk("R8 no extra frame", riseTotal - base, 64);
    chk("R8 ready held", {31'd0, reqReady}, 32'd1);

    chk("R4 mdio timing violations", viol, 0);
    chk("R7 high phase length", lastHi, DIV);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule